// File: doc/BRIEF.md
# PWM shadow-register synchronization unit

This block sits beside a PWM timer and holds the double-buffered copies of three of its control registers: the counter start value, the software output override word and the per-pair output swap mask. Software always writes into a buffer. Each buffer is copied into its active register under one of two policies. The first policy copies it on every clock. The second copies it only when a one-cycle synchronization pulse arrives. Each of the three registers has its own select bit in a configuration register, so one register can track its buffer continuously while another waits for the pulse.

The active swap mask is applied combinationally to pairs of PWM channel outputs. When a pair's bit is set, the even and odd channels of that pair exchange their signals. The block also holds three hardware trigger request flags, which software arms by writing ones. A trigger pulse that meets an armed flag is reported on an output. A mode bit then decides whether that detection clears the flag or leaves it armed. A further configuration bit chooses between the legacy and the enhanced synchronization style and is passed out to the rest of the timer.

Register map (address on `wr_addr`/`rd_addr`): 0 configuration, 1 counter start buffer, 2 software override buffer, 3 swap mask buffer, 4 trigger flags. Configuration bits: 0 trigger keep mode, 1 counter start select, 2 override select, 3 swap select, 4 enhanced mode.

Top module: `pwm_shadow_sync`

## Requirements
- R1: After reset, every buffer, every active register, the configuration and the trigger flags are 0. `pwm_out` then equals `pwm_in`, and `enh_sync_o` is 0.
- R2: With its select bit at 0, an active register takes its buffer value at every rising clock edge. A written value appears at the active output one cycle after the write edge.
- R3: With its select bit at 1, an active register keeps its value until a cycle in which `sync_pulse` is 1. At that edge it loads the buffer value.
- R4: The three select bits (configuration bits 1, 2 and 3) act independently. A register on the pulse policy does not stop another register on the every-clock policy from updating.
- R5: Reading addresses 1, 2 or 3 returns the buffer value, including the value just written, and not the active value.
- R6: For each pair m with its active swap bit set, `pwm_out[2m]` equals `pwm_in[2m+1]` and `pwm_out[2m+1]` equals `pwm_in[2m]`. Pairs with a clear bit pass straight through, with no clock delay.
- R7: Writing a 1 to bit j at address 4 arms flag j. With configuration bit 0 at 0, a trigger pulse on `trig_in[j]` while flag j is armed clears flag j at that edge.
- R8: With configuration bit 0 at 1, a detected trigger leaves its flag armed.
- R9: Configuration bits above bit 4 and trigger-flag bits above bit 2 ignore writes and read as 0. Unmapped addresses read as 0.
- R10: `enh_sync_o` follows configuration bit 4, one cycle after the write edge.
- R11: `trig_fire_o[j]` is 1 exactly when `trig_in[j]` is 1 and flag j is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | DATA_W (16) | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | DATA_W (16) | Combinational read data |
| sync_pulse | input | 1 | One-cycle synchronization event |
| trig_in | input | NTRIG (3) | Hardware trigger pulses |
| pwm_in | input | 2*NPAIRS (8) | PWM channel signals before the swap |
| pwm_out | output | 2*NPAIRS (8) | PWM channel signals after the swap |
| cnt_init_o | output | CNT_W (16) | Active counter start value |
| swctl_o | output | SWCTL_W (16) | Active software override word |
| trig_fire_o | output | NTRIG (3) | Trigger detected against an armed flag |
| enh_sync_o | output | 1 | Enhanced synchronization mode selected |

## Verification
The bench builds the block with its defaults: four channel pairs, three triggers, and 16-bit data, counter and override words. With these values, every pair of the swap network, every trigger flag and the full write-data width can be driven. Swapping pairs 0 and 2 with a channel pattern that differs within those pairs shows both the swap and the pass-through of the other pairs. Mixed select settings, with one register waiting for the pulse while another tracks its buffer, bring the independence of the update policies and the one-cycle lag of the continuous policy into view.

// File: rtl/pss_pkg.sv
package pss_pkg;

  localparam int ADDR_W = 3;
  localparam int CFG_W  = 5;

  typedef enum logic [ADDR_W-1:0] {
    A_CFG     = 3'd0,
    A_CNTINIT = 3'd1,
    A_SWCTL   = 3'd2,
    A_SWAP    = 3'd3,
    A_TRIG    = 3'd4
  } addr_e;

  // packed MSB first: enh is bit 4, trig_keep is bit 0
  typedef struct packed {
    logic enh;
    logic swap_sel;
    logic swctl_sel;
    logic cnt_sel;
    logic trig_keep;
  } cfg_t;

endpackage

// File: rtl/pss_rst_sync.sv
module pss_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end

endmodule

// File: rtl/pss_shadow_reg.sv
module pss_shadow_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         on_sync,
  input  logic         sync_pulse,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] buf_q,
  output logic [W-1:0] act_q
);

  logic [W-1:0] buf_d;
  logic [W-1:0] act_d;
  logic         act_en;

  always_comb begin
    buf_d  = wr_en ? wr_data : buf_q;
    act_en = !on_sync || sync_pulse;
    act_d  = act_en ? buf_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      buf_q <= buf_d;
      act_q <= act_d;
    end
  end

  AST_CONT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(on_sync) |-> act_q == $past(buf_q)) else $error("continuous update missed"); // R2

  AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(on_sync && !sync_pulse) |-> $stable(act_q)) else $error("active changed without pulse"); // R3

  AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(on_sync && sync_pulse) |-> act_q == $past(buf_q)) else $error("pulse load missed"); // R3

endmodule

// File: rtl/pss_trig_flags.sv
module pss_trig_flags #(
  parameter int NTRIG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             keep,
  input  logic [NTRIG-1:0] set_mask,
  input  logic [NTRIG-1:0] trig_in,
  output logic [NTRIG-1:0] flag_q,
  output logic [NTRIG-1:0] fire
);

  logic [NTRIG-1:0] flag_d;
  logic [NTRIG-1:0] clr_mask;

  always_comb begin
    fire     = trig_in & flag_q;
    clr_mask = keep ? '0 : fire;
    flag_d   = (flag_q & ~clr_mask) | set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  AST_TRIG_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q & $past(set_mask)) == $past(set_mask)) else $error("arm lost"); // R7

  AST_TRIG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(keep) |-> (flag_q & $past(trig_in & flag_q & ~set_mask)) == '0) else $error("flag not cleared"); // R7

  AST_TRIG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(keep) |-> ($past(flag_q) & ~flag_q) == '0) else $error("flag dropped in keep mode"); // R8

endmodule

// File: rtl/pss_pair_swap.sv
module pss_pair_swap #(
  parameter int NPAIRS = 4
) (
  input  logic [NPAIRS-1:0]   swap_en,
  input  logic [2*NPAIRS-1:0] pwm_i,
  output logic [2*NPAIRS-1:0] pwm_o
);

  for (genvar m = 0; m < NPAIRS; m++) begin : g_pair
    always_comb begin
      if (swap_en[m]) begin
        pwm_o[2*m]   = pwm_i[2*m+1];
        pwm_o[2*m+1] = pwm_i[2*m];
      end else begin
        pwm_o[2*m]   = pwm_i[2*m];
        pwm_o[2*m+1] = pwm_i[2*m+1];
      end
    end
  end

endmodule

// File: rtl/pwm_shadow_sync.sv
module pwm_shadow_sync #(
  parameter int NPAIRS  = 4,
  parameter int NTRIG   = 3,
  parameter int CNT_W   = 16,
  parameter int SWCTL_W = 16,
  parameter int DATA_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [pss_pkg::ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [pss_pkg::ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  input  logic                       sync_pulse,
  input  logic [NTRIG-1:0]           trig_in,
  input  logic [2*NPAIRS-1:0]        pwm_in,
  output logic [2*NPAIRS-1:0]        pwm_out,
  output logic [CNT_W-1:0]           cnt_init_o,
  output logic [SWCTL_W-1:0]         swctl_o,
  output logic [NTRIG-1:0]           trig_fire_o,
  output logic                       enh_sync_o
);

  import pss_pkg::*;

  localparam int NCH = 2 * NPAIRS;

  logic rst_i_n;

  pss_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_i_n)
  );

  // write decode
  logic wr_cfg, wr_cnt, wr_swctl, wr_swap, wr_trig;

  always_comb begin
    wr_cfg   = wr_en && (wr_addr == A_CFG);
    wr_cnt   = wr_en && (wr_addr == A_CNTINIT);
    wr_swctl = wr_en && (wr_addr == A_SWCTL);
    wr_swap  = wr_en && (wr_addr == A_SWAP);
    wr_trig  = wr_en && (wr_addr == A_TRIG);
  end

  // configuration register, written directly
  cfg_t cfg_q;
  cfg_t cfg_d;

  always_comb begin
    cfg_d = wr_cfg ? cfg_t'(wr_data[CFG_W-1:0]) : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) cfg_q <= '0;
    else          cfg_q <= cfg_d;
  end

  assign enh_sync_o = cfg_q.enh;

  // buffered registers
  logic [CNT_W-1:0]   cnt_buf;
  logic [SWCTL_W-1:0] swctl_buf;
  logic [NPAIRS-1:0]  swap_buf;
  logic [NPAIRS-1:0]  swap_act;

  pss_shadow_reg #(.W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .on_sync   (cfg_q.cnt_sel),
    .sync_pulse(sync_pulse),
    .wr_en     (wr_cnt),
    .wr_data   (wr_data[CNT_W-1:0]),
    .buf_q     (cnt_buf),
    .act_q     (cnt_init_o)
  );

  pss_shadow_reg #(.W(SWCTL_W)) u_swctl (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .on_sync   (cfg_q.swctl_sel),
    .sync_pulse(sync_pulse),
    .wr_en     (wr_swctl),
    .wr_data   (wr_data[SWCTL_W-1:0]),
    .buf_q     (swctl_buf),
    .act_q     (swctl_o)
  );

  pss_shadow_reg #(.W(NPAIRS)) u_swap (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .on_sync   (cfg_q.swap_sel),
    .sync_pulse(sync_pulse),
    .wr_en     (wr_swap),
    .wr_data   (wr_data[NPAIRS-1:0]),
    .buf_q     (swap_buf),
    .act_q     (swap_act)
  );

  // trigger flags
  logic [NTRIG-1:0] flag_q;
  logic [NTRIG-1:0] arm_mask;

  assign arm_mask = wr_trig ? wr_data[NTRIG-1:0] : '0;

  pss_trig_flags #(.NTRIG(NTRIG)) u_trig (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .keep    (cfg_q.trig_keep),
    .set_mask(arm_mask),
    .trig_in (trig_in),
    .flag_q  (flag_q),
    .fire    (trig_fire_o)
  );

  // channel pair swap
  pss_pair_swap #(.NPAIRS(NPAIRS)) u_swp (
    .swap_en(swap_act),
    .pwm_i  (pwm_in),
    .pwm_o  (pwm_out)
  );

  // read mux
  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CFG:     rd_data = DATA_W'(cfg_q);
      A_CNTINIT: rd_data = DATA_W'(cnt_buf);
      A_SWCTL:   rd_data = DATA_W'(swctl_buf);
      A_SWAP:    rd_data = DATA_W'(swap_buf);
      A_TRIG:    rd_data = DATA_W'(flag_q);
      default:   rd_data = '0;
    endcase
  end

  AST_SWAP_ONES: assert property (@(posedge clk) disable iff (!rst_i_n)
    $countones(pwm_out) == $countones(pwm_in)) else $error("swap lost a channel"); // R6

  AST_CFG_RSVD: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_addr == A_CFG) |-> (rd_data >> CFG_W) == '0) else $error("reserved cfg bits set"); // R9

  AST_ENH_FOLLOW: assert property (@(posedge clk) disable iff (!rst_i_n)
    $past(wr_cfg) |-> enh_sync_o == $past(wr_data[CFG_W-1])) else $error("mode bit not taken"); // R10

  AST_FIRE_FLAG: assert property (@(posedge clk) disable iff (!rst_i_n)
    (trig_fire_o & ~flag_q) == '0) else $error("fire without armed flag"); // R11

  initial begin
    if (NCH != 2 * NPAIRS) $error("channel count mismatch");
  end

endmodule

// File: tb/pwm_shadow_sync_bench.sv
module pwm_shadow_sync_bench;

  localparam int NPAIRS  = 4;
  localparam int NTRIG   = 3;
  localparam int CNT_W   = 16;
  localparam int SWCTL_W = 16;
  localparam int DATA_W  = 16;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                wr_en;
  logic [2:0]          wr_addr;
  logic [DATA_W-1:0]   wr_data;
  logic [2:0]          rd_addr;
  logic [DATA_W-1:0]   rd_data;
  logic                sync_pulse;
  logic [NTRIG-1:0]    trig_in;
  logic [2*NPAIRS-1:0] pwm_in;
  logic [2*NPAIRS-1:0] pwm_out;
  logic [CNT_W-1:0]    cnt_init_o;
  logic [SWCTL_W-1:0]  swctl_o;
  logic [NTRIG-1:0]    trig_fire_o;
  logic                enh_sync_o;

  always #2.5 clk = ~clk;

  pwm_shadow_sync #(
    .NPAIRS(NPAIRS), .NTRIG(NTRIG), .CNT_W(CNT_W), .SWCTL_W(SWCTL_W), .DATA_W(DATA_W)
  ) u_pwm_shadow_sync (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sync_pulse(sync_pulse), .trig_in(trig_in),
    .pwm_in(pwm_in), .pwm_out(pwm_out), .cnt_init_o(cnt_init_o), .swctl_o(swctl_o),
    .trig_fire_o(trig_fire_o), .enh_sync_o(enh_sync_o)
  );

  // observed quantities
  localparam int K_RD = 0, K_CNT = 1, K_SWCTL = 2, K_PWM = 3, K_FIRE = 4, K_ENH = 5;

  typedef struct {
    string       req;
    int          kind;
    logic [31:0] exp;
  } item_t;

  item_t q[$];
  int    n_chk  = 0;
  int    n_err  = 0;
  bit    done   = 1'b0;

  task automatic expect_item(input string req, input int kind, input logic [31:0] exp);
    item_t it;
    it.req  = req;
    it.kind = kind;
    it.exp  = exp;
    q.push_back(it);
  endtask

  // monitor: compares between clock edges
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it = q.pop_front();
        case (it.kind)
          K_RD:    got = 32'(rd_data);
          K_CNT:   got = 32'(cnt_init_o);
          K_SWCTL: got = 32'(swctl_o);
          K_PWM:   got = 32'(pwm_out);
          K_FIRE:  got = 32'(trig_fire_o);
          default: got = 32'(enh_sync_o);
        endcase
        n_chk++;
        if (got !== it.exp) begin
          n_err++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, got, it.exp);
        end
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    tick(1);
    wr_en   = 1'b0;
  endtask

  task automatic pulse_sync();
    sync_pulse = 1'b1;
    tick(1);
    sync_pulse = 1'b0;
  endtask

  function automatic logic [2*NPAIRS-1:0] swap_ref(input logic [2*NPAIRS-1:0] v,
                                                    input logic [NPAIRS-1:0] m);
    logic [2*NPAIRS-1:0] r;
    r = v;
    for (int p = 0; p < NPAIRS; p++) begin
      if (m[p]) begin
        r[2*p]   = v[2*p+1];
        r[2*p+1] = v[2*p];
      end
    end
    return r;
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    sync_pulse = 1'b0; trig_in = '0; pwm_in = 8'h96;
    tick(4);
    rst_n = 1'b1;
    tick(3);

    // R1 reset state
    rd_addr = 3'd0; expect_item("R1", K_RD, 32'h0);
    expect_item("R1", K_CNT, 32'h0);
    expect_item("R1", K_SWCTL, 32'h0);
    expect_item("R1", K_PWM, 32'h96);
    expect_item("R1", K_ENH, 32'h0);
    tick(1);
    rd_addr = 3'd4; expect_item("R1", K_RD, 32'h0);
    tick(1);

    // R2 continuous update, R5 buffer readback
    wr(3'd1, 16'h1234);
    rd_addr = 3'd1; expect_item("R5", K_RD, 32'h1234);
    expect_item("R2", K_CNT, 32'h0);
    tick(1);
    expect_item("R2", K_CNT, 32'h1234);
    tick(1);

    // R3 pulse policy on counter start, R4 override stays continuous
    wr(3'd0, 16'h0002);
    wr(3'd1, 16'h00AB);
    wr(3'd2, 16'h5A5A);
    tick(3);
    expect_item("R3", K_CNT, 32'h1234);
    expect_item("R4", K_SWCTL, 32'h5A5A);
    rd_addr = 3'd1; expect_item("R5", K_RD, 32'h00AB);
    tick(1);
    pulse_sync();
    expect_item("R3", K_CNT, 32'h00AB);
    tick(1);

    // R6 swap on pulse policy
    wr(3'd0, 16'h0008);
    wr(3'd3, 16'h0005);
    tick(2);
    expect_item("R6", K_PWM, 32'h96);
    rd_addr = 3'd3; expect_item("R5", K_RD, 32'h5);
    tick(1);
    pulse_sync();
    expect_item("R6", K_PWM, 32'(swap_ref(8'h96, 4'h5)));
    tick(1);
    pwm_in = 8'h3C;
    #1 expect_item("R6", K_PWM, 32'(swap_ref(8'h3C, 4'h5)));
    tick(1);
    wr(3'd0, 16'h0000);
    wr(3'd3, 16'h0000);
    tick(1);
    expect_item("R6", K_PWM, 32'h3C);
    tick(1);

    // R9 reserved bits, R10 mode output
    wr(3'd0, 16'hFFFF);
    rd_addr = 3'd0; expect_item("R9", K_RD, 32'h1F);
    expect_item("R10", K_ENH, 32'h1);
    tick(1);
    wr(3'd0, 16'h0000);
    expect_item("R10", K_ENH, 32'h0);
    rd_addr = 3'd6; expect_item("R9", K_RD, 32'h0);
    tick(1);

    // R7 arm and clear, R11 fire
    wr(3'd4, 16'h0007);
    rd_addr = 3'd4; expect_item("R7", K_RD, 32'h7);
    tick(1);
    trig_in = 3'b010;
    expect_item("R11", K_FIRE, 32'h2);
    tick(1);
    trig_in = 3'b000;
    expect_item("R7", K_RD, 32'h5);
    tick(1);

    // R8 keep mode
    wr(3'd0, 16'h0001);
    trig_in = 3'b001;
    expect_item("R11", K_FIRE, 32'h1);
    tick(1);
    trig_in = 3'b000;
    expect_item("R8", K_RD, 32'h5);
    tick(1);

    // R11 unarmed trigger does not fire
    trig_in = 3'b010;
    expect_item("R11", K_FIRE, 32'h0);
    tick(1);
    trig_in = 3'b000;
    expect_item("R11", K_RD, 32'h5);
    tick(1);

    // R9 reserved flag bits
    wr(3'd4, 16'hFFF8);
    expect_item("R9", K_RD, 32'h5);
    tick(2);

    done = 1'b1;
    summary();
  end

endmodule